// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block keeps a small, fully associative set of recent page translations. Each entry holds a virtual page number, the address-space identifier of the process that owns it, a physical frame number, a writable flag and a pinned flag. A lookup presents a page number, the current identifier and an access type. In the same cycle every entry is compared, and a hit returns the frame and the writable flag. A miss is reported, so that an outside agent can walk the page table and hand the result back on the fill port.

Tagging every entry with its owner's identifier means that a context switch needs no flush. Pinned entries stay resident through every replacement and every flush. Two invalidate commands are provided: one clears all unpinned entries, the other clears only the unpinned entries of one identifier. Replacement fills free slots first. Once the cache is full it cycles round-robin over the unpinned slots.

Top module: `tlb_asid`

## Requirements
- R1: While `lk_valid` is high and a valid entry matches both `lk_vpn` and `lk_asid`, `lk_hit` is high in the same cycle, and `lk_frame` and `lk_writable` carry that entry's frame number and writable flag (1 = read-write, 0 = read-only).
- R2: `lk_miss` is high exactly when `lk_valid` is high and no valid entry matches. While `lk_valid` is low, both `lk_hit` and `lk_miss` are low.
- R3: An entry whose page number matches but whose identifier differs from `lk_asid` does not hit.
- R4: `lk_fault` is high exactly when a lookup hits, `lk_write` is high and the hit entry is read-only.
- R5: A translation presented with `fill_valid` is stored at the clock edge, and a lookup of it in any later cycle hits.
- R6: A fill whose page number and identifier equal those of a valid entry rewrites that entry in place. All other entries are kept, and no second copy is made.
- R7: A fill that matches no entry goes to the lowest-indexed invalid entry when one exists.
- R8: With no invalid entry, a fill replaces the first unpinned entry at or after a round-robin pointer, wrapping around. The pointer is 0 after reset and moves to one past each evicted index.
- R9: An entry filled with `fill_wired` high is never chosen for replacement and is not cleared by either flush. A later fill of the same translation with `fill_wired` low unpins it.
- R10: `flush_all` clears every unpinned entry at the clock edge.
- R11: `flush_asid` clears only the unpinned entries whose identifier equals `flush_asid_id`.
- R12: After reset every entry is invalid, so every lookup misses.
- R13: A fill that matches no entry while every entry is pinned is dropped and changes nothing.
- R14: When a fill and a flush occur in the same cycle, the slot is chosen from the state before the flush, and the filled entry survives the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Identifier of the current address space |
| lk_write | input | 1 | The access is a write |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Translation absent, refill needed |
| lk_frame | output | PFN_W | Frame number of the hit entry |
| lk_writable | output | 1 | Hit entry allows writes |
| lk_fault | output | 1 | Write to a read-only page |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page number to install |
| fill_asid | input | ASID_W | Identifier to install |
| fill_frame | input | PFN_W | Frame number to install |
| fill_writable | input | 1 | Writable flag to install |
| fill_wired | input | 1 | Pin the installed entry |
| flush_all | input | 1 | Clear all unpinned entries |
| flush_asid | input | 1 | Clear the unpinned entries of one identifier |
| flush_asid_id | input | ASID_W | Identifier selected by `flush_asid` |

## Verification
The bench goes after the cases where a slot-selection error stays hidden until later. A refill of an existing translation must rewrite its own slot; a design that made a duplicate would give up a slot and later evict a translation too early. The first eviction after the table fills must land on slot 0. A pinned slot must be skipped while the pointer wraps; a design that evicted it would lose a translation that should survive every flush. Further cases are a fill arriving while every slot is pinned, which a faulty design would write over a pinned entry, a fill in the same cycle as a flush, which a faulty design would clear, and a per-identifier flush, which a faulty design would apply to the other identifiers as well.

// File: rtl/tlb_asid_pkg.sv
package tlb_asid_pkg;
   // How a fill picks the slot it writes.
   typedef enum logic [1:0] {
      SRC_MATCH = 2'd0,   // rewrite the entry already holding this translation
      SRC_FREE  = 2'd1,   // lowest invalid slot
      SRC_EVICT = 2'd2,   // round-robin over unpinned slots
      SRC_NONE  = 2'd3    // every slot pinned: drop the fill
   } fill_src_e;
endpackage

// File: rtl/tlb_asid_match.sv
module tlb_asid_match #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int ASID_W  = 8
) (
   input  logic [ENTRIES-1:0] valid,
   input  logic [VPN_W-1:0]   ent_vpn  [ENTRIES],
   input  logic [ASID_W-1:0]  ent_asid [ENTRIES],
   input  logic [VPN_W-1:0]   key_vpn,
   input  logic [ASID_W-1:0]  key_asid,
   output logic [ENTRIES-1:0] match
);
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = valid[g] && (ent_vpn[g] == key_vpn) && (ent_asid[g] == key_asid);
   end
endmodule

// File: rtl/tlb_asid_victim.sv
module tlb_asid_victim
   import tlb_asid_pkg::*;
#(
   parameter int ENTRIES = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0] match,
   input  logic [ENTRIES-1:0] valid,
   input  logic [ENTRIES-1:0] wired,
   input  logic [IDX_W-1:0]   rr_ptr,
   output logic [IDX_W-1:0]   sel_idx,
   output fill_src_e          sel_src
);
   logic [IDX_W-1:0] match_idx, free_idx, evict_idx, cand;
   logic             any_match, any_free, any_evict;

   always_comb begin
      match_idx = '0;
      any_match = 1'b0;
      free_idx  = '0;
      any_free  = 1'b0;
      evict_idx = '0;
      any_evict = 1'b0;
      cand      = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match[i]) begin
            match_idx = IDX_W'(i);
            any_match = 1'b1;
         end
         if (!valid[i]) begin
            free_idx = IDX_W'(i);
            any_free = 1'b1;
         end
      end
      // descending offset so the smallest offset from the pointer wins
      for (int k = ENTRIES - 1; k >= 0; k--) begin
         cand = rr_ptr + IDX_W'(k);
         if (!wired[cand]) begin
            evict_idx = cand;
            any_evict = 1'b1;
         end
      end
      if (any_match) begin
         sel_idx = match_idx;
         sel_src = SRC_MATCH;
      end else if (any_free) begin
         sel_idx = free_idx;
         sel_src = SRC_FREE;
      end else if (any_evict) begin
         sel_idx = evict_idx;
         sel_src = SRC_EVICT;
      end else begin
         sel_idx = '0;
         sel_src = SRC_NONE;
      end
   end
endmodule

// File: rtl/tlb_asid.sv
module tlb_asid
   import tlb_asid_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 16,
   parameter int ASID_W  = 8,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic              lk_write,
   output logic              lk_hit,
   output logic              lk_miss,
   output logic [PFN_W-1:0]  lk_frame,
   output logic              lk_writable,
   output logic              lk_fault,
   input  logic              fill_valid,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [ASID_W-1:0] fill_asid,
   input  logic [PFN_W-1:0]  fill_frame,
   input  logic              fill_writable,
   input  logic              fill_wired,
   input  logic              flush_all,
   input  logic              flush_asid,
   input  logic [ASID_W-1:0] flush_asid_id
);
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("tlb_asid: ENTRIES must be a power of two of at least 2");
   end
   if (VPN_W < 1 || PFN_W < 1 || ASID_W < 1) begin : g_bad_width
      $error("tlb_asid: field widths must be positive");
   end

   logic [ENTRIES-1:0] valid_q, wired_q, wr_q;
   logic [VPN_W-1:0]   vpn_q   [ENTRIES];
   logic [ASID_W-1:0]  asid_q  [ENTRIES];
   logic [PFN_W-1:0]   frame_q [ENTRIES];
   logic [IDX_W-1:0]   rr_ptr;

   logic [ENTRIES-1:0] lk_match, fill_match, flush_hit;
   logic [IDX_W-1:0]   sel_idx;
   fill_src_e          sel_src;
   logic               fill_do;

   tlb_asid_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
      .valid(valid_q), .ent_vpn(vpn_q), .ent_asid(asid_q),
      .key_vpn(lk_vpn), .key_asid(lk_asid), .match(lk_match)
   );

   tlb_asid_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_match (
      .valid(valid_q), .ent_vpn(vpn_q), .ent_asid(asid_q),
      .key_vpn(fill_vpn), .key_asid(fill_asid), .match(fill_match)
   );

   tlb_asid_victim #(.ENTRIES(ENTRIES)) u_victim (
      .match(fill_match), .valid(valid_q), .wired(wired_q), .rr_ptr(rr_ptr),
      .sel_idx(sel_idx), .sel_src(sel_src)
   );

   // read side: at most one entry matches, so an OR of masked fields selects it
   always_comb begin
      lk_frame    = '0;
      lk_writable = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         lk_frame    = lk_frame | (frame_q[i] & {PFN_W{lk_match[i]}});
         lk_writable = lk_writable | (wr_q[i] & lk_match[i]);
      end
   end

   assign lk_hit   = lk_valid && (|lk_match);
   assign lk_miss  = lk_valid && !(|lk_match);
   assign lk_fault = lk_hit && lk_write && !lk_writable;

   assign fill_do = fill_valid && (sel_src != SRC_NONE);

   for (genvar g = 0; g < ENTRIES; g++) begin : g_flush
      assign flush_hit[g] = !wired_q[g] &&
                            (flush_all || (flush_asid && asid_q[g] == flush_asid_id)) &&
                            !(fill_do && sel_idx == IDX_W'(g));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         wired_q <= '0;
         rr_ptr  <= '0;
      end else begin
         valid_q <= valid_q & ~flush_hit;
         if (fill_do) begin
            valid_q[sel_idx] <= 1'b1;
            wired_q[sel_idx] <= fill_wired;
         end
         if (fill_valid && sel_src == SRC_EVICT) begin
            rr_ptr <= sel_idx + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fill_do) begin
         vpn_q[sel_idx]   <= fill_vpn;
         asid_q[sel_idx]  <= fill_asid;
         frame_q[sel_idx] <= fill_frame;
         wr_q[sel_idx]    <= fill_writable;
      end
   end
endmodule

// File: rtl/tlb_asid_chk.sv
module tlb_asid_chk #(
   parameter int ENTRIES = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_valid,
   input logic               lk_write,
   input logic               lk_hit,
   input logic               lk_miss,
   input logic               lk_writable,
   input logic               lk_fault,
   input logic               fill_valid,
   input logic               flush_all,
   input logic [ENTRIES-1:0] lk_match,
   input logic [ENTRIES-1:0] valid_q,
   input logic [ENTRIES-1:0] wired_q
);
   // R2
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> (!lk_hit && !lk_miss));
   // R2
   a_r2_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> (lk_hit != lk_miss));
   // R4
   a_r4_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
      lk_fault |-> (lk_hit && lk_write && !lk_writable));
   // R6: refills never create a second copy
   a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match));
   // R9
   a_r9_pinned_stay: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (($past(valid_q & wired_q) & ~valid_q) == '0));
   // R10
   a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_all && !fill_valid) |=> ((valid_q & ~wired_q) == '0));
endmodule

bind tlb_asid tlb_asid_chk #(.ENTRIES(ENTRIES)) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
   .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_writable(lk_writable), .lk_fault(lk_fault),
   .fill_valid(fill_valid), .flush_all(flush_all),
   .lk_match(lk_match), .valid_q(valid_q), .wired_q(wired_q)
);

// File: tb/tb_tlb_asid.sv
module tb_tlb_asid;
   localparam int N  = 16;
   localparam int VW = 20;
   localparam int PW = 16;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lk_valid, lk_write, fill_valid, fill_writable, fill_wired;
   logic          flush_all, flush_asid;
   logic [VW-1:0] lk_vpn, fill_vpn;
   logic [AW-1:0] lk_asid, fill_asid, flush_asid_id;
   logic [PW-1:0] fill_frame, lk_frame;
   logic          lk_hit, lk_miss, lk_writable, lk_fault;

   always #10 clk = ~clk;   // 50 MHz

   tlb_asid #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW), .ASID_W(AW)) dut (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_write(lk_write),
      .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_frame(lk_frame),
      .lk_writable(lk_writable), .lk_fault(lk_fault),
      .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
      .fill_frame(fill_frame), .fill_writable(fill_writable), .fill_wired(fill_wired),
      .flush_all(flush_all), .flush_asid(flush_asid), .flush_asid_id(flush_asid_id)
   );

   // behavioural reference state
   bit     m_v [N];
   bit     m_w [N];
   bit     m_wr[N];
   int     m_vpn[N];
   int     m_as [N];
   int     m_fr [N];
   int     m_rr;
   int     checks = 0;
   int     errors = 0;
   bit     done = 0;
   string  cur_req = "R12";

   function automatic int m_find(int vpn, int asid);
      for (int i = 0; i < N; i++)
         if (m_v[i] && m_vpn[i] == vpn && m_as[i] == asid) return i;
      return -1;
   endfunction

   task automatic model_clock();
      int  t;
      bit  evict;
      t = -1;
      evict = 0;
      if (fill_valid) begin
         t = m_find(int'(fill_vpn), int'(fill_asid));
         if (t < 0)
            for (int i = 0; i < N; i++) if (!m_v[i] && t < 0) t = i;
         if (t < 0)
            for (int k = 0; k < N; k++)
               if (t < 0 && !m_w[(m_rr + k) % N]) begin
                  t = (m_rr + k) % N;
                  evict = 1;
               end
      end
      for (int i = 0; i < N; i++)
         if (!m_w[i] && i != t &&
             (flush_all || (flush_asid && m_as[i] == int'(flush_asid_id)))) m_v[i] = 0;
      if (t >= 0) begin
         m_v[t] = 1;  m_w[t] = fill_wired;  m_wr[t] = fill_writable;
         m_vpn[t] = int'(fill_vpn);  m_as[t] = int'(fill_asid);  m_fr[t] = int'(fill_frame);
         if (evict) m_rr = (t + 1) % N;
      end
   endtask

   // one cycle: inputs are already set (after a falling edge)
   task automatic cyc();
      int  e;
      bit  eh, em, ef, ew;
      int  efr;
      #2;
      e   = lk_valid ? m_find(int'(lk_vpn), int'(lk_asid)) : -1;
      eh  = lk_valid && e >= 0;
      em  = lk_valid && e < 0;
      ew  = eh ? m_wr[e] : 1'b0;
      efr = eh ? m_fr[e] : 0;
      ef  = eh && lk_write && !ew;
      checks++;
      if (lk_hit !== eh || lk_miss !== em || lk_fault !== ef ||
          (eh && (int'(lk_frame) != efr || lk_writable !== ew))) begin
         errors++;
         $display("FAIL %s: vpn=%h asid=%h got hit=%b miss=%b fault=%b frame=%h wr=%b expected hit=%b miss=%b fault=%b frame=%h wr=%b",
                  cur_req, lk_vpn, lk_asid, lk_hit, lk_miss, lk_fault, lk_frame, lk_writable,
                  eh, em, ef, efr[PW-1:0], ew);
      end
      @(posedge clk);
      if (rst_n) model_clock();
      @(negedge clk);
   endtask

   task automatic idle();
      lk_valid = 0; lk_write = 0; lk_vpn = '0; lk_asid = '0;
      fill_valid = 0; fill_vpn = '0; fill_asid = '0; fill_frame = '0;
      fill_writable = 0; fill_wired = 0;
      flush_all = 0; flush_asid = 0; flush_asid_id = '0;
   endtask

   task automatic look(int vpn, int asid, bit wr);
      idle();
      lk_valid = 1; lk_vpn = VW'(vpn); lk_asid = AW'(asid); lk_write = wr;
      cyc();
   endtask

   task automatic fill(int vpn, int asid, int frame, bit wr, bit pin);
      idle();
      fill_valid = 1; fill_vpn = VW'(vpn); fill_asid = AW'(asid);
      fill_frame = PW'(frame); fill_writable = wr; fill_wired = pin;
      cyc();
   endtask

   task automatic sweep(int base, int cnt, int asid);
      for (int i = 0; i < cnt; i++) look(base + i, asid, i[0]);
   endtask

   initial begin
      #(20 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_v[i] = 0; m_w[i] = 0; m_wr[i] = 0; m_vpn[i] = 0; m_as[i] = 0; m_fr[i] = 0;
      end
      m_rr = 0;
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1;

      cur_req = "R12";                 // empty after reset
      sweep(32'h100, 4, 1);

      cur_req = "R5";                  // install then hit
      for (int i = 0; i < 4; i++) fill(32'h100 + i, 1, 32'h200 + i, i[0], 0);
      cur_req = "R1";
      sweep(32'h100, 4, 1);
      cur_req = "R3";                  // other identifier misses
      sweep(32'h100, 4, 2);
      cur_req = "R4";                  // write to read-only faults, read-write does not
      look(32'h100, 1, 1);
      look(32'h101, 1, 1);
      look(32'h100, 1, 0);
      cur_req = "R2";                  // no request, no answer
      idle(); cyc(); cyc();
      look(32'hABC, 1, 0);

      cur_req = "R6";                  // refill in place
      fill(32'h101, 1, 32'h2AA, 1, 0);
      sweep(32'h100, 4, 1);

      cur_req = "R7";                  // free slots fill up in index order
      for (int i = 4; i < N; i++) fill(32'h100 + i, 1, 32'h200 + i, 1, 0);
      sweep(32'h100, N, 1);

      cur_req = "R8";                  // first eviction hits slot 0, then onward
      fill(32'h300, 3, 32'h333, 0, 1);
      for (int i = 0; i < 3; i++) fill(32'h400 + i, 1, 32'h440 + i, 1, 0);
      sweep(32'h100, N, 1);
      sweep(32'h400, 3, 1);
      look(32'h300, 3, 1);

      cur_req = "R10";
      idle(); flush_all = 1; cyc();
      sweep(32'h100, N, 1);
      sweep(32'h400, 3, 1);
      cur_req = "R9";                  // pinned survives
      look(32'h300, 3, 0);

      cur_req = "R11";
      for (int i = 0; i < 3; i++) fill(32'h500 + i, 4, 32'h550 + i, 1, 0);
      for (int i = 0; i < 3; i++) fill(32'h600 + i, 5, 32'h660 + i, 0, 0);
      idle(); flush_asid = 1; flush_asid_id = 8'd4; cyc();
      sweep(32'h500, 3, 4);
      sweep(32'h600, 3, 5);
      look(32'h300, 3, 0);
      cur_req = "R7";
      fill(32'h700, 6, 32'h777, 1, 0);
      look(32'h700, 6, 0);

      cur_req = "R14";                 // fill and flush together
      idle();
      flush_all = 1;
      fill_valid = 1; fill_vpn = 20'h800; fill_asid = 8'd7; fill_frame = 16'h888; fill_writable = 1;
      cyc();
      look(32'h800, 7, 0);
      look(32'h700, 6, 0);
      sweep(32'h600, 3, 5);

      cur_req = "R13";                 // pin everything, then a new fill is dropped
      for (int i = 0; i < N - 1; i++) fill(32'h900 + i, 8, 32'h990 + i, 1, 1);
      fill(32'h777, 9, 32'h123, 1, 0);
      look(32'h777, 9, 0);
      sweep(32'h900, N - 1, 8);
      look(32'h300, 3, 0);
      idle(); flush_all = 1; cyc();
      cur_req = "R9";
      sweep(32'h900, N - 1, 8);
      look(32'h300, 3, 0);
      fill(32'h300, 3, 32'h301, 1, 0);  // unpin
      fill(32'h778, 9, 32'h124, 0, 0);  // only unpinned slot is evicted
      look(32'h300, 3, 0);
      look(32'h778, 9, 1);
      sweep(32'h900, N - 1, 8);

      cur_req = "R12";                 // second reset empties the table
      idle();
      rst_n = 0;
      for (int i = 0; i < N; i++) begin m_v[i] = 0; m_w[i] = 0; end
      m_rr = 0;
      @(negedge clk);
      rst_n = 1;
      sweep(32'h900, 4, 8);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule